// File: doc/BRIEF.md
# Transmit Descriptor Ring Walker

This block drives the transmit side of a frame controller whose buffer descriptors sit in a local descriptor memory. Every descriptor takes two 32-bit words. The first word carries the length in its upper half and the control and status bits in its lower half. The second word carries the buffer address. Software fills a descriptor and sets its ready bit to hand it to hardware. The walker finds that descriptor and presents its address, length and framing requests to an abstract transmitter. When the transmitter reports done, the walker writes back the completion status and moves on to the next slot.

The transmit and receive descriptors share one table. A count input marks how many entries, starting from index 0, belong to transmit. The walk returns to index 0 after the last of those entries, or earlier when a descriptor carries a wrap flag. A completed descriptor can ask for a one-cycle interrupt pulse on the transmit-done source. Collision handling and the line interface belong to the transmitter and are outside this block.

Top module: `tx_bd_walker`

## Requirements
- R1: While reset is held, and in the cycle after it is released, no memory read, memory write, transmit request or interrupt is driven.
- R2: Descriptor i is read as two single-cycle reads. The control word comes from byte address TABLE_BASE + 8*i, and one read later the buffer address comes from TABLE_BASE + 8*i + 4. Read data arrives one cycle after the read strobe, and a read and a write never share a cycle.
- R3: If the control word has bit 15 (ready) clear, no transmit request is issued. The walker keeps re-reading the control word of the same index until software sets bit 15.
- R4: For a ready descriptor, tx_req rises and stays high until tx_done is sampled. While it is high, the outputs hold the buffer address (second word), the length (control word bits 31:16), pad (bit 12) and CRC append (bit 11), all unchanged.
- R5: In the cycle after tx_done is sampled, the walker writes the control word back to its own address. Bits 31:16 keep the length, bit 15 is cleared, bits 14:9 keep their values, and bits 8:0 take tx_status (bit 8 underrun, bits 7:4 retry count, bit 3 retry limit, bit 2 late collision, bit 1 defer, bit 0 carrier lost).
- R6: irq_txdone pulses high for exactly the write-back cycle of a descriptor whose bit 14 is set, and at no other time.
- R7: After a descriptor with bit 13 (wrap) set completes, the next index read is 0.
- R8: After index desc_count-1 completes, the next index read is 0. Indices at or above desc_count are never read in a walk.
- R9: With tx_enable low, the walker reads nothing. Clearing tx_enable during a transmission lets that descriptor finish and write back, then the walker stops. Setting it again resumes at the following index.
- R10: With desc_count equal to 0, nothing is read even with tx_enable high.

Top module port list follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_enable | input | 1 | Transmit enable |
| desc_count | input | IW+1 | Number of table entries owned by transmit |
| dm_rd_en | output | 1 | Descriptor memory read strobe |
| dm_wr_en | output | 1 | Descriptor memory write strobe |
| dm_addr | output | AW | Descriptor memory byte address |
| dm_wdata | output | 32 | Descriptor memory write data |
| dm_rdata | input | 32 | Descriptor memory read data, one cycle after the strobe |
| tx_req | output | 1 | Frame ready for the transmitter |
| tx_buf_addr | output | 32 | Buffer address of the frame |
| tx_len | output | 16 | Frame length in bytes |
| tx_pad | output | 1 | Pad short frame request |
| tx_crc | output | 1 | Append CRC request |
| tx_done | input | 1 | Transmitter finished the current frame |
| tx_status | input | 9 | Completion status, valid with tx_done |
| irq_txdone | output | 1 | Transmit-done interrupt source pulse |

## Verification
The bench builds the walker with an 8-entry table at the default base of 0x400. A table this small lets it sweep every transmit count from 1 to 4 from a fresh reset, serving every descriptor of each ring and then watching the walker poll index 0 after the lap. Ready entries placed beyond the count act as traps, so any overrun shows up as a wrong frame. Separate runs cover an early wrap flag, enable dropped in the middle of a frame, and a zero count.

// File: rtl/tx_bd_walker.sv
module tx_bd_walker #(
  parameter int DESC_TOTAL = 128,
  parameter int AW         = 12,
  parameter int TABLE_BASE = 'h400,
  localparam int IW        = $clog2(DESC_TOTAL)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tx_enable,
  input  logic [IW:0]   desc_count,
  output logic          dm_rd_en,
  output logic          dm_wr_en,
  output logic [AW-1:0] dm_addr,
  output logic [31:0]   dm_wdata,
  input  logic [31:0]   dm_rdata,
  output logic          tx_req,
  output logic [31:0]   tx_buf_addr,
  output logic [15:0]   tx_len,
  output logic          tx_pad,
  output logic          tx_crc,
  input  logic          tx_done,
  input  logic [8:0]    tx_status,
  output logic          irq_txdone
);
  localparam logic [AW-1:0] BASE_A = AW'(TABLE_BASE);

  typedef enum logic [2:0] {S_IDLE, S_FCTL, S_CHK, S_FPTR, S_LOAD, S_XMIT, S_WB} st_t;

  st_t         st;
  logic [IW-1:0] idx;
  logic [15:0] len_q;
  logic [5:0]  ctl_q;
  logic [31:0] ptr_q;
  logic [8:0]  sts_q;

  wire run_ok  = tx_enable && (desc_count != '0);
  wire at_last = ctl_q[4] || ({1'b0, idx} >= desc_count - (IW+1)'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      idx   <= '0;
      len_q <= '0;
      ctl_q <= '0;
      ptr_q <= '0;
      sts_q <= '0;
    end else begin
      case (st)
        S_IDLE: if (run_ok) begin
          st <= S_FCTL;
          if ({1'b0, idx} >= desc_count) idx <= '0;
        end
        S_FCTL: st <= S_CHK;
        S_CHK: begin
          len_q <= dm_rdata[31:16];
          ctl_q <= dm_rdata[14:9];
          if (!tx_enable)       st <= S_IDLE;
          else if (dm_rdata[15]) st <= S_FPTR;
          else                  st <= S_FCTL;
        end
        S_FPTR: st <= S_LOAD;
        S_LOAD: begin
          ptr_q <= dm_rdata;
          st    <= S_XMIT;
        end
        S_XMIT: if (tx_done) begin
          sts_q <= tx_status;
          st    <= S_WB;
        end
        S_WB: begin
          idx <= at_last ? '0 : idx + IW'(1);
          st  <= run_ok ? S_FCTL : S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign dm_rd_en    = (st == S_FCTL) || (st == S_FPTR);
  assign dm_wr_en    = (st == S_WB);
  assign dm_addr     = BASE_A + AW'({idx, 3'b000}) + ((st == S_FPTR) ? AW'(4) : AW'(0));
  assign dm_wdata    = {len_q, 1'b0, ctl_q, sts_q};
  assign tx_req      = (st == S_XMIT);
  assign tx_buf_addr = ptr_q;
  assign tx_len      = len_q;
  assign tx_pad      = ctl_q[3];
  assign tx_crc      = ctl_q[2];
  assign irq_txdone  = (st == S_WB) && ctl_q[5];

  AST_ONE_MEM_OP: assert property (@(posedge clk) disable iff (!rst_n) !(dm_rd_en && dm_wr_en)); // R2
  AST_POLL_SAME_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_CHK && !dm_rdata[15]) |=> (idx == $past(idx))); // R3
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_req && !tx_done) |=> (tx_req && $stable(tx_buf_addr) && $stable(tx_len))); // R4
  AST_WB_FOLLOWS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_req && tx_done) |=> (dm_wr_en && !tx_req)); // R5
  AST_IRQ_ON_WB: assert property (@(posedge clk) disable iff (!rst_n)
    irq_txdone |-> (dm_wr_en && dm_wdata[14])); // R6
  AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_txdone |=> !irq_txdone); // R6
endmodule

// File: tb/tx_bd_walker_bench.sv
module tx_bd_walker_bench;
  localparam int NT = 8;
  localparam int IW = $clog2(NT);
  localparam logic [11:0] BASE = 12'h400;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n = 1'b0, tx_enable = 1'b0, tx_done = 1'b0;
  logic [IW:0] desc_count = '0;
  logic [8:0]  tx_status = '0;
  logic        dm_rd_en, dm_wr_en, tx_req, tx_pad, tx_crc, irq_txdone;
  logic [11:0] dm_addr;
  logic [31:0] dm_wdata, dm_rdata, tx_buf_addr;
  logic [15:0] tx_len;

  tx_bd_walker #(.DESC_TOTAL(NT), .AW(12), .TABLE_BASE('h400)) u_tx_bd_walker (
    .clk(clk), .rst_n(rst_n), .tx_enable(tx_enable), .desc_count(desc_count),
    .dm_rd_en(dm_rd_en), .dm_wr_en(dm_wr_en), .dm_addr(dm_addr), .dm_wdata(dm_wdata),
    .dm_rdata(dm_rdata), .tx_req(tx_req), .tx_buf_addr(tx_buf_addr), .tx_len(tx_len),
    .tx_pad(tx_pad), .tx_crc(tx_crc), .tx_done(tx_done), .tx_status(tx_status),
    .irq_txdone(irq_txdone));

  logic [31:0] mem [0:2*NT-1];
  wire  [3:0]  widx = 4'((dm_addr - BASE) >> 2);
  always @(posedge clk) begin
    if (dm_rd_en) dm_rdata <= mem[widx];
    if (dm_wr_en) mem[widx] <= dm_wdata;
  end

  int total = 0, bad = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] e_len(int n, int k); return 16'(100 + 16*n + k); endfunction
  function automatic logic [31:0] e_ptr(int n, int k); return 32'h1000_0000 + 32'(n << 12) + 32'(k << 4); endfunction
  function automatic logic [8:0]  e_sts(int n, int k); return 9'((n*37 + k*11) & 'h1ff); endfunction
  function automatic logic [31:0] ctl_word(int n, int k, bit rdy, bit wrap, logic [8:0] sts);
    bit irq = (k % 2 == 0);
    bit pad = k[0];
    return {e_len(n, k), rdy, irq, wrap, pad, ~pad, 2'b00, sts};
  endfunction

  task automatic put_desc(int n, int k, bit rdy, bit wrap);
    mem[2*k]   = ctl_word(n, k, rdy, wrap, 9'h0);
    mem[2*k+1] = e_ptr(n, k);
  endtask

  task automatic do_reset();
    @(negedge clk);
    tx_enable = 1'b0; rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic serve(int n, int k, bit wrap, string tag);
    int waited = 0;
    while (!tx_req && waited < 300) begin @(negedge clk); waited++; end
    chk(tx_req, {tag, " R4 request seen"}, 32'(tx_req), 1);
    chk(tx_buf_addr == e_ptr(n, k), {tag, " R4 buffer address"}, tx_buf_addr, e_ptr(n, k));
    chk(tx_len == e_len(n, k), {tag, " R4 length"}, 32'(tx_len), 32'(e_len(n, k)));
    chk({tx_pad, tx_crc} == {k[0], ~k[0]}, {tag, " R4 pad/crc"}, 32'({tx_pad, tx_crc}), 32'({k[0], ~k[0]}));
    repeat (k + 1) @(negedge clk);
    chk(tx_req && tx_buf_addr == e_ptr(n, k), {tag, " R4 request held"}, tx_buf_addr, e_ptr(n, k));
    tx_done = 1'b1; tx_status = e_sts(n, k);
    @(negedge clk);
    tx_done = 1'b0;
    chk(dm_wr_en, {tag, " R5 write-back strobe"}, 32'(dm_wr_en), 1);
    chk(dm_addr == BASE + 12'(8*k), {tag, " R5 write-back address"}, 32'(dm_addr), 32'(BASE + 12'(8*k)));
    chk(dm_wdata == ctl_word(n, k, 1'b0, wrap, e_sts(n, k)), {tag, " R5 write-back word"},
        dm_wdata, ctl_word(n, k, 1'b0, wrap, e_sts(n, k)));
    chk(irq_txdone == (k % 2 == 0), {tag, " R6 irq on completion"}, 32'(irq_txdone), 32'(k % 2 == 0));
    @(negedge clk);
    chk(!irq_txdone && !tx_req, {tag, " R6 irq single pulse"}, 32'(irq_txdone), 0);
  endtask

  task automatic quiet(int cycles, bit expect_rd, string tag);
    int reqs = 0, rds = 0, wrong = 0;
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk);
      if (tx_req) reqs++;
      if (dm_rd_en) begin rds++; if (dm_addr != BASE) wrong++; end
    end
    chk(reqs == 0, {tag, " no transmit request"}, 32'(reqs), 0);
    if (expect_rd) begin
      chk(rds > 0, {tag, " R3 polling continues"}, 32'(rds), 1);
      chk(wrong == 0, {tag, " R3 R8 polls index 0 only"}, 32'(wrong), 0);
    end else
      chk(rds == 0, {tag, " no descriptor reads"}, 32'(rds), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int k = 0; k < NT; k++) put_desc(1, k, 1'b1, 1'b0);
    repeat (2) @(negedge clk);
    chk(!dm_rd_en && !dm_wr_en && !tx_req && !irq_txdone, "R1 outputs quiet in reset", 32'({dm_rd_en, dm_wr_en, tx_req, irq_txdone}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!dm_rd_en && !dm_wr_en && !tx_req && !irq_txdone, "R1 outputs quiet after reset", 32'({dm_rd_en, dm_wr_en, tx_req, irq_txdone}), 0);

    desc_count = 2;
    quiet(20, 1'b0, "R9 enable low");
    desc_count = 0; tx_enable = 1'b1;
    quiet(20, 1'b0, "R10 zero count");
    tx_enable = 1'b0;

    for (int n = 1; n <= 4; n++) begin
      do_reset();
      for (int k = 0; k < NT; k++) put_desc(n, k, 1'b1, 1'b0);
      desc_count = (IW+1)'(n);
      tx_enable = 1'b1;
      for (int k = 0; k < n; k++) serve(n, k, 1'b0, $sformatf("R2 R8 sweep n=%0d k=%0d", n, k));
      quiet(30, 1'b1, $sformatf("R3 R8 lap end n=%0d", n));
      put_desc(n, 0, 1'b1, 1'b0);
      serve(n, 0, 1'b0, $sformatf("R3 rearmed n=%0d", n));
    end

    do_reset();
    for (int k = 0; k < NT; k++) put_desc(4, k, 1'b1, k == 1);
    desc_count = 4; tx_enable = 1'b1;
    serve(4, 0, 1'b0, "R7 wrap first");
    serve(4, 1, 1'b1, "R7 wrap flagged");
    quiet(30, 1'b1, "R7 after wrap");

    do_reset();
    for (int k = 0; k < NT; k++) put_desc(2, k, 1'b1, 1'b0);
    desc_count = 2; tx_enable = 1'b1;
    while (!tx_req) @(negedge clk);
    tx_enable = 1'b0;
    serve(2, 0, 1'b0, "R9 finish after disable");
    quiet(20, 1'b0, "R9 stopped");
    tx_enable = 1'b1;
    serve(2, 1, 1'b0, "R9 resume next index");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule